// File: doc/BRIEF.md
# Prioritized Interrupt Vector Resolver

This block sits beside a small CPU core and decides, at each instruction boundary, which pending interrupt the core takes next. It collects fourteen maskable request lines, four non-maskable events and an internal reset-service request. It also keeps the two interrupt mask bits and a promotion register that moves one maskable source to the head of the order. When a request wins, the block raises a one-cycle take strobe and presents the 16-bit address of the vector slot that the core must fetch.

The core marks the last cycle of each instruction with a boundary signal. Requests are only resolved in that cycle, so an instruction is never cut in half. The core also reports writes to the mask bits, returns from interrupt with the saved mask bits, and writes to the promotion register. Register stacking and the fetch itself stay in the core.

Top module: `intr_vector_resolver`

## Requirements
- R1: While reset is active, and after it is released, take_o is 0, imask_o is 1 and xmask_o is 1, and the promotion register is 0. The first boundary after reset takes the reset-service vector 0xFFFE, even with the I mask set.
- R2: A take is resolved only in a cycle with boundary_i high. take_o is high for exactly the one cycle after that boundary cycle. vector_o is valid in that cycle and holds its value afterwards. Without a boundary, take_o stays 0 whatever is pending.
- R3: Maskable requests (mreq_i) are ignored while imask_o is 1 and are taken while it is 0.
- R4: Every take sets imask_o to 1 at the same edge that raises take_o. A mask write or a return that clears I in the boundary cycle of a take loses, and imask_o ends at 1.
- R5: A return (rti_i) loads imask_o from rti_i_bit_i. It takes priority over a mask write (ccr_we_i) in the same cycle.
- R6: xmask_o may be cleared by a mask write or a return that carries a 0 X bit. Once it is 0, no write, no return and no take sets it again before the next reset.
- R7: Non-maskable sources ignore imask_o and beat every maskable request. Their order, from highest, is: reset service 0xFFFE, watchdog failure cop_fail_i 0xFFFA, illegal opcode 0xFFF8, software interrupt 0xFFF6, external non-maskable xirq_i 0xFFF4. xirq_i only counts while xmask_o is 0.
- R8: With no promotion, maskable index 0 has the highest priority and index 13 the lowest. Index k (k = 0 to 11) uses vector 0xFFF2 - 2k. Index 12 uses 0xFFD8 and index 13 uses 0xFFD6.
- R9: A write to the promotion register (prio_we_i) stores a 4-bit index p. If p < 14 and request p is active and unmasked, p wins over all other maskable requests. Otherwise the R8 order applies unchanged, and values 14 and 15 leave the default order.
- R10: illop_pulse_i and swi_pulse_i are one-cycle pulses. Each is latched until it is taken and cleared by that take. The level sources (cop_fail_i, xirq_i, mreq_i) are evaluated again at every boundary while they stay asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released in step with clk |
| boundary_i | input | 1 | Last cycle of the current instruction |
| mreq_i | input | 14 | Maskable request levels, index 0 highest by default |
| cop_fail_i | input | 1 | Watchdog failure request level |
| illop_pulse_i | input | 1 | Illegal-opcode event pulse |
| swi_pulse_i | input | 1 | Software-interrupt event pulse |
| xirq_i | input | 1 | External non-maskable request level |
| ccr_we_i | input | 1 | Mask-bit write strobe |
| ccr_i_bit_i | input | 1 | I value written by ccr_we_i |
| ccr_x_bit_i | input | 1 | X value written by ccr_we_i (only a 0 has an effect) |
| rti_i | input | 1 | Return from interrupt, restores the saved mask bits |
| rti_i_bit_i | input | 1 | Saved I bit restored by rti_i |
| rti_x_bit_i | input | 1 | Saved X bit restored by rti_i (only a 0 has an effect) |
| prio_we_i | input | 1 | Promotion register write strobe |
| prio_wdata_i | input | 4 | Promoted maskable source index |
| take_o | output | 1 | One-cycle take-interrupt strobe |
| vector_o | output | 16 | Vector slot address, held between takes |
| imask_o | output | 1 | Current I mask bit |
| xmask_o | output | 1 | Current X mask bit |

## Verification
A take and a software change to the I mask can fall in the same cycle. The bench provokes this in two ways. It drives boundary_i with a mask write that clears I while a maskable request is pending. It also drives boundary_i with a return that restores I = 0 while the watchdog request is high. In both cases the bench expects the take with its vector and expects imask_o to read 1 afterwards. Latched pulses meeting a boundary are also covered: several pulses wait together, and the bench expects them to drain one boundary at a time in priority order and leave nothing behind.

// File: rtl/intr_res_pkg.sv
package intr_res_pkg;

  localparam int unsigned NUM_MSK = 14;
  localparam int unsigned PRIO_W  = 4;

  localparam logic [15:0] VEC_RESET = 16'hFFFE;
  localparam logic [15:0] VEC_COP   = 16'hFFFA;
  localparam logic [15:0] VEC_ILLOP = 16'hFFF8;
  localparam logic [15:0] VEC_SWI   = 16'hFFF6;
  localparam logic [15:0] VEC_XIRQ  = 16'hFFF4;
  localparam logic [15:0] VEC_MTOP  = 16'hFFF2;

  typedef enum logic [2:0] {
    NM_NONE  = 3'd0,
    NM_RESET = 3'd1,
    NM_COP   = 3'd2,
    NM_ILLOP = 3'd3,
    NM_SWI   = 3'd4,
    NM_XIRQ  = 3'd5
  } nm_src_e;

  // Slot address of a maskable source. The two serial sources skip one slot.
  function automatic logic [15:0] msk_vector(input int unsigned idx);
    int unsigned slot;
    slot = (idx < 12) ? idx : idx + 1;
    return VEC_MTOP - 16'(2 * slot);
  endfunction

  function automatic logic [15:0] nm_vector(input nm_src_e src);
    logic [15:0] v;
    unique case (src)
      NM_RESET: v = VEC_RESET;
      NM_COP:   v = VEC_COP;
      NM_ILLOP: v = VEC_ILLOP;
      NM_SWI:   v = VEC_SWI;
      NM_XIRQ:  v = VEC_XIRQ;
      default:  v = 16'h0000;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/intr_event_latch.sv
module intr_event_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic illop_pulse_i,
  input  logic swi_pulse_i,
  input  logic clr_reset_i,
  input  logic clr_illop_i,
  input  logic clr_swi_i,
  output logic reset_pend_o,
  output logic illop_pend_o,
  output logic swi_pend_o
);

  logic reset_q, reset_d;
  logic illop_q, illop_d;
  logic swi_q,   swi_d;

  always_comb begin
    reset_d = reset_q & ~clr_reset_i;
    illop_d = (illop_q & ~clr_illop_i) | illop_pulse_i;
    swi_d   = (swi_q & ~clr_swi_i) | swi_pulse_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reset_q <= 1'b1;
      illop_q <= 1'b0;
      swi_q   <= 1'b0;
    end else begin
      reset_q <= reset_d;
      illop_q <= illop_d;
      swi_q   <= swi_d;
    end
  end

  assign reset_pend_o = reset_q;
  assign illop_pend_o = illop_q;
  assign swi_pend_o   = swi_q;

  // R1
  reset_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reset_q |=> !reset_q);

  // R10
  swi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swi_q && !clr_swi_i |=> swi_q);

endmodule

// File: rtl/intr_mask_state.sv
module intr_mask_state #(
  parameter int unsigned PRIO_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_set_i,
  input  logic              ccr_we_i,
  input  logic              ccr_i_bit_i,
  input  logic              ccr_x_bit_i,
  input  logic              rti_i,
  input  logic              rti_i_bit_i,
  input  logic              rti_x_bit_i,
  input  logic              prio_we_i,
  input  logic [PRIO_W-1:0] prio_wdata_i,
  output logic              imask_o,
  output logic              xmask_o,
  output logic [PRIO_W-1:0] prio_o
);

  logic              imask_q, imask_d;
  logic              xmask_q, xmask_d;
  logic [PRIO_W-1:0] prio_q;
  logic              prio_en;

  always_comb begin
    imask_d = imask_q;
    xmask_d = xmask_q;
    if (rti_i) begin
      imask_d = rti_i_bit_i;
      xmask_d = xmask_q & rti_x_bit_i;
    end else if (ccr_we_i) begin
      imask_d = ccr_i_bit_i;
      xmask_d = xmask_q & ccr_x_bit_i;
    end
    if (take_set_i) begin
      imask_d = 1'b1;
    end
  end

  assign prio_en = prio_we_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      imask_q <= 1'b1;
      xmask_q <= 1'b1;
    end else begin
      imask_q <= imask_d;
      xmask_q <= xmask_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prio_q <= '0;
    end else if (prio_en) begin
      prio_q <= prio_wdata_i;
    end
  end

  assign imask_o = imask_q;
  assign xmask_o = xmask_q;
  assign prio_o  = prio_q;

  // R6
  xmask_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !xmask_q |=> !xmask_q);

  // R4
  take_masks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_set_i |=> imask_q);

  // R5
  rti_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rti_i && !take_set_i |=> imask_q == $past(rti_i_bit_i));

endmodule

// File: rtl/intr_msk_arb.sv
module intr_msk_arb #(
  parameter int unsigned N      = 14,
  parameter int unsigned PRIO_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      req_i,
  input  logic [PRIO_W-1:0] prio_i,
  output logic [N-1:0]      grant_o,
  output logic              any_o,
  output logic [IDX_W-1:0]  idx_o
);

  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1;

  logic [N:0]   blocked;
  logic [N-1:0] fixed_grant;
  logic [N-1:0] promo_sel;
  logic         promo_hit;

  assign blocked[0] = 1'b0;

  generate
    for (genvar k = 0; k < N; k++) begin : g_slot
      assign fixed_grant[k] = req_i[k] & ~blocked[k];
      assign blocked[k+1]   = blocked[k] | req_i[k];
      assign promo_sel[k]   = (prio_i == PRIO_W'(k));
    end
  endgenerate

  assign promo_hit = |(req_i & promo_sel);
  assign grant_o   = promo_hit ? (req_i & promo_sel) : fixed_grant;
  assign any_o     = blocked[N];

  always_comb begin
    idx_o = '0;
    for (int k = 0; k < N; k++) begin
      if (grant_o[k]) begin
        idx_o = idx_o | IDX_W'(k);
      end
    end
  end

  // R9
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));

  // R8
  grant_in_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o & ~req_i) == '0);

  // R8
  grant_when_any_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_o |-> $countones(grant_o) == 1);

endmodule

// File: rtl/intr_vector_resolver.sv
module intr_vector_resolver
  import intr_res_pkg::*;
#(
  parameter int unsigned N_MSK = NUM_MSK,
  parameter int unsigned P_W   = PRIO_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             boundary_i,
  input  logic [N_MSK-1:0] mreq_i,
  input  logic             cop_fail_i,
  input  logic             illop_pulse_i,
  input  logic             swi_pulse_i,
  input  logic             xirq_i,
  input  logic             ccr_we_i,
  input  logic             ccr_i_bit_i,
  input  logic             ccr_x_bit_i,
  input  logic             rti_i,
  input  logic             rti_i_bit_i,
  input  logic             rti_x_bit_i,
  input  logic             prio_we_i,
  input  logic [P_W-1:0]   prio_wdata_i,
  output logic             take_o,
  output logic [15:0]      vector_o,
  output logic             imask_o,
  output logic             xmask_o
);

  localparam int unsigned IDX_W = (N_MSK > 1) ? $clog2(N_MSK) : 1;

  logic             reset_pend, illop_pend, swi_pend;
  logic             imask, xmask;
  logic [P_W-1:0]   prio;
  logic [N_MSK-1:0] msk_req, msk_grant;
  logic             msk_any;
  logic [IDX_W-1:0] msk_idx;
  nm_src_e          nm_win;
  logic             take_now;
  logic [15:0]      vec_now;
  logic             take_q;
  logic [15:0]      vec_q;

  intr_event_latch u_events (
    .clk           (clk),
    .rst_n         (rst_n),
    .illop_pulse_i (illop_pulse_i),
    .swi_pulse_i   (swi_pulse_i),
    .clr_reset_i   (take_now && nm_win == NM_RESET),
    .clr_illop_i   (take_now && nm_win == NM_ILLOP),
    .clr_swi_i     (take_now && nm_win == NM_SWI),
    .reset_pend_o  (reset_pend),
    .illop_pend_o  (illop_pend),
    .swi_pend_o    (swi_pend)
  );

  intr_mask_state #(.PRIO_W(P_W)) u_masks (
    .clk          (clk),
    .rst_n        (rst_n),
    .take_set_i   (take_now),
    .ccr_we_i     (ccr_we_i),
    .ccr_i_bit_i  (ccr_i_bit_i),
    .ccr_x_bit_i  (ccr_x_bit_i),
    .rti_i        (rti_i),
    .rti_i_bit_i  (rti_i_bit_i),
    .rti_x_bit_i  (rti_x_bit_i),
    .prio_we_i    (prio_we_i),
    .prio_wdata_i (prio_wdata_i),
    .imask_o      (imask),
    .xmask_o      (xmask),
    .prio_o       (prio)
  );

  assign msk_req = mreq_i & {N_MSK{~imask}};

  intr_msk_arb #(.N(N_MSK), .PRIO_W(P_W)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_i   (msk_req),
    .prio_i  (prio),
    .grant_o (msk_grant),
    .any_o   (msk_any),
    .idx_o   (msk_idx)
  );

  // Fixed order among non-maskable sources.
  always_comb begin
    if (reset_pend)            nm_win = NM_RESET;
    else if (cop_fail_i)       nm_win = NM_COP;
    else if (illop_pend)       nm_win = NM_ILLOP;
    else if (swi_pend)         nm_win = NM_SWI;
    else if (xirq_i && !xmask) nm_win = NM_XIRQ;
    else                       nm_win = NM_NONE;
  end

  always_comb begin
    take_now = boundary_i && (nm_win != NM_NONE || msk_any);
    if (nm_win != NM_NONE) vec_now = nm_vector(nm_win);
    else                   vec_now = msk_vector(int'(msk_idx));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_q <= 1'b0;
    end else begin
      take_q <= take_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q <= VEC_RESET;
    end else if (take_now) begin
      vec_q <= vec_now;
    end
  end

  assign take_o   = take_q;
  assign vector_o = vec_q;
  assign imask_o  = imask;
  assign xmask_o  = xmask;

  // R2
  take_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary_i |=> !take_o);

  // R2
  vector_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take_o |-> $stable(vector_o));

  // R4
  take_sets_i_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> imask_o);

  // R3
  masked_no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_o && vector_o <= VEC_MTOP |-> $past(!imask_o));

  // R7
  xirq_needs_clear_x_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_o && vector_o == VEC_XIRQ |-> !xmask_o);

endmodule

// File: tb/intr_vector_resolver_tb_top.sv
module intr_vector_resolver_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        boundary_i, cop_fail_i, illop_pulse_i, swi_pulse_i, xirq_i;
  logic [13:0] mreq_i;
  logic        ccr_we_i, ccr_i_bit_i, ccr_x_bit_i;
  logic        rti_i, rti_i_bit_i, rti_x_bit_i;
  logic        prio_we_i;
  logic [3:0]  prio_wdata_i;
  logic        take_o, imask_o, xmask_o;
  logic [15:0] vector_o;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  intr_vector_resolver dut_i (
    .clk(clk), .rst_n(rst_n), .boundary_i(boundary_i), .mreq_i(mreq_i),
    .cop_fail_i(cop_fail_i), .illop_pulse_i(illop_pulse_i),
    .swi_pulse_i(swi_pulse_i), .xirq_i(xirq_i), .ccr_we_i(ccr_we_i),
    .ccr_i_bit_i(ccr_i_bit_i), .ccr_x_bit_i(ccr_x_bit_i), .rti_i(rti_i),
    .rti_i_bit_i(rti_i_bit_i), .rti_x_bit_i(rti_x_bit_i),
    .prio_we_i(prio_we_i), .prio_wdata_i(prio_wdata_i), .take_o(take_o),
    .vector_o(vector_o), .imask_o(imask_o), .xmask_o(xmask_o)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Vector slot of maskable index k, from the requirement text.
  function automatic logic [15:0] exp_vec(input int k);
    if (k == 12) return 16'hFFD8;
    if (k == 13) return 16'hFFD6;
    return 16'(32'hFFF2 - 2 * k);
  endfunction

  function automatic int exp_win(input logic [13:0] req, input int p);
    if (p < 14 && req[p]) return p;
    for (int k = 0; k < 14; k++) if (req[k]) return k;
    return -1;
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic boundary();
    boundary_i = 1'b1;
    tick();
    boundary_i = 1'b0;
  endtask

  task automatic wr_ccr(input logic i, input logic x);
    ccr_we_i = 1'b1; ccr_i_bit_i = i; ccr_x_bit_i = x;
    tick();
    ccr_we_i = 1'b0;
  endtask

  task automatic do_rti(input logic i, input logic x);
    rti_i = 1'b1; rti_i_bit_i = i; rti_x_bit_i = x;
    tick();
    rti_i = 1'b0;
  endtask

  task automatic wr_prio(input logic [3:0] p);
    prio_we_i = 1'b1; prio_wdata_i = p;
    tick();
    prio_we_i = 1'b0;
  endtask

  task automatic expect_take(input string req, input logic [15:0] v);
    chk(req, "take", {31'd0, take_o}, 32'd1);
    chk(req, "vector", {16'd0, vector_o}, {16'd0, v});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; boundary_i = 0; mreq_i = '0; cop_fail_i = 0;
    illop_pulse_i = 0; swi_pulse_i = 0; xirq_i = 0; ccr_we_i = 0;
    ccr_i_bit_i = 0; ccr_x_bit_i = 0; rti_i = 0; rti_i_bit_i = 0;
    rti_x_bit_i = 0; prio_we_i = 0; prio_wdata_i = '0;
    repeat (3) tick();
    chk("R1", "take in reset", {31'd0, take_o}, 32'd0);
    chk("R1", "imask in reset", {31'd0, imask_o}, 32'd1);
    chk("R1", "xmask in reset", {31'd0, xmask_o}, 32'd1);
    rst_n = 1'b1;
    repeat (4) tick();
    chk("R2", "no take without boundary", {31'd0, take_o}, 32'd0);
    boundary();
    expect_take("R1", 16'hFFFE);
    tick();
    chk("R2", "strobe one cycle", {31'd0, take_o}, 32'd0);
    chk("R1", "imask after reset take", {31'd0, imask_o}, 32'd1);

    // R3: masked requests are ignored
    mreq_i = '1;
    boundary();
    chk("R3", "masked take", {31'd0, take_o}, 32'd0);
    wr_ccr(1'b0, 1'b1);
    chk("R6", "write 1 to X keeps 1", {31'd0, xmask_o}, 32'd1);
    repeat (3) tick();
    chk("R2", "pending but no boundary", {31'd0, take_o}, 32'd0);
    boundary();
    expect_take("R3", 16'hFFF2);
    chk("R4", "I set by take", {31'd0, imask_o}, 32'd1);
    mreq_i = '0;

    // R8 / R9 sweep: every promotion value against all singles and pairs
    for (int p = 0; p < 16; p++) begin
      wr_prio(4'(p));
      for (int a = 0; a < 14; a++) begin
        for (int b = a; b < 14; b++) begin
          wr_ccr(1'b0, 1'b1);
          mreq_i = '0; mreq_i[a] = 1'b1; mreq_i[b] = 1'b1;
          boundary();
          expect_take((p < 14) ? "R9" : "R8", exp_vec(exp_win(mreq_i, p)));
          mreq_i = '0;
        end
      end
    end
    tick();
    chk("R4", "I set after sweep", {31'd0, imask_o}, 32'd1);

    // R5: return restores I
    do_rti(1'b0, 1'b1);
    chk("R5", "rti clears I", {31'd0, imask_o}, 32'd0);
    mreq_i = 14'h0020;
    boundary();
    expect_take("R5", 16'hFFE8);
    do_rti(1'b1, 1'b1);
    chk("R5", "rti sets I", {31'd0, imask_o}, 32'd1);
    boundary();
    chk("R5", "masked after rti", {31'd0, take_o}, 32'd0);
    rti_i = 1'b1; rti_i_bit_i = 1'b0; ccr_we_i = 1'b1; ccr_i_bit_i = 1'b1;
    tick();
    rti_i = 1'b0; ccr_we_i = 1'b0;
    chk("R5", "rti beats write", {31'd0, imask_o}, 32'd0);

    // R4: take and clearing write in the same cycle
    mreq_i = 14'h0008;
    boundary_i = 1'b1; ccr_we_i = 1'b1; ccr_i_bit_i = 1'b0; ccr_x_bit_i = 1'b1;
    tick();
    boundary_i = 1'b0; ccr_we_i = 1'b0;
    expect_take("R4", 16'hFFEC);
    chk("R4", "take beats write", {31'd0, imask_o}, 32'd1);
    mreq_i = '0;
    cop_fail_i = 1'b1;
    boundary_i = 1'b1; rti_i = 1'b1; rti_i_bit_i = 1'b0; rti_x_bit_i = 1'b1;
    tick();
    boundary_i = 1'b0; rti_i = 1'b0; cop_fail_i = 1'b0;
    expect_take("R4", 16'hFFFA);
    chk("R4", "take beats rti", {31'd0, imask_o}, 32'd1);

    // R6 / R7: external non-maskable request
    xirq_i = 1'b1;
    boundary();
    chk("R6", "xirq blocked by X", {31'd0, take_o}, 32'd0);
    wr_ccr(1'b1, 1'b0);
    chk("R6", "X cleared", {31'd0, xmask_o}, 32'd0);
    boundary();
    expect_take("R7", 16'hFFF4);
    xirq_i = 1'b0;
    wr_ccr(1'b1, 1'b1);
    chk("R6", "write cannot set X", {31'd0, xmask_o}, 32'd0);
    do_rti(1'b1, 1'b1);
    chk("R6", "rti cannot set X", {31'd0, xmask_o}, 32'd0);

    // R7: order among non-maskable sources and over maskable ones
    wr_ccr(1'b0, 1'b0);
    mreq_i = '1; xirq_i = 1'b1;
    boundary();
    expect_take("R7", 16'hFFF4);
    cop_fail_i = 1'b1;
    boundary();
    expect_take("R7", 16'hFFFA);
    cop_fail_i = 1'b0;
    swi_pulse_i = 1'b1; tick(); swi_pulse_i = 1'b0;
    illop_pulse_i = 1'b1; tick(); illop_pulse_i = 1'b0;
    tick();
    boundary();
    expect_take("R7", 16'hFFF8);
    boundary();
    expect_take("R7", 16'hFFF6);
    boundary();
    expect_take("R7", 16'hFFF4);
    xirq_i = 1'b0;
    boundary();
    chk("R10", "pulses cleared by take", {31'd0, take_o}, 32'd0);
    mreq_i = '0;

    // R10: pulse latched across cycles, level re-evaluated
    swi_pulse_i = 1'b1; tick(); swi_pulse_i = 1'b0;
    repeat (5) tick();
    boundary();
    expect_take("R10", 16'hFFF6);
    cop_fail_i = 1'b1;
    boundary();
    expect_take("R10", 16'hFFFA);
    boundary();
    expect_take("R10", 16'hFFFA);
    cop_fail_i = 1'b0;
    tick();
    chk("R2", "vector held", {16'd0, vector_o}, 32'h0000FFFA);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule